// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns a stream of single-beat read and write requests into SDRAM commands for one rank with four internal banks. It remembers which row is open in each bank. It opens rows with ACTIVATE, closes them with PRECHARGE, and issues READ or WRITE once the programmed spacing since the previous command allows it. A programmable interval timer runs at the SDRAM clock and raises a refresh demand. That demand preempts waiting requests: all open banks are closed, then an AUTO-REFRESH is issued. The block also produces a read-data-valid strobe timed by the CAS latency.

Every delay field is encoded so that a value `v` means `v+1` clocks. Commands are decided combinationally from the registered state and the request, then registered. `sd_cmd`, `sd_addr` and `sd_bank` therefore show a command in the cycle after the request handshake. The controller FSM has three states:

- `ST_OFF`: always issues NOP. It moves to `ST_RUN` when enabled.
- `ST_RUN`: serves refresh demand or requests. It moves to `ST_REF_WAIT` after a precharge-all, and back to `ST_OFF` when disabled.
- `ST_REF_WAIT`: issues AUTO-REFRESH once the precharge gap has elapsed. It then moves to `ST_RUN`, or to `ST_OFF` when disabled.

Configuration inputs may only change while `cfg_enable` is low.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Reset, and any cycle with `cfg_enable` low, yields NOP (`sd_cmd`=0) from the following cycle, with `req_ready` low and no `rd_data_valid`.
- R2: An ACTIVATE (code 1) is followed by a READ (code 2) or WRITE (code 3) no sooner than `cfg_act_to_rw`+1 cycles later, and exactly that many cycles later when a request to the opened row is waiting.
- R3: A READ or WRITE is followed by a PRECHARGE (code 4) no sooner than `cfg_rw_to_pre`+1 cycles later, and exactly that when the precharge is waiting.
- R4: A PRECHARGE or AUTO-REFRESH (code 5) is followed by an ACTIVATE or AUTO-REFRESH no sooner than `cfg_pre_to_act`+1 cycles later, and exactly that when the follow-up is waiting.
- R5: A request whose bank has the requested row open is accepted with `req_ready` and issued as READ or WRITE without ACTIVATE. The command carries the bank on `sd_bank` and the column on `sd_addr[COL_W-1:0]`.
- R6: A request to a bank holding a different row first gets a single-bank PRECHARGE (`sd_addr[10]`=0, that bank on `sd_bank`). This is followed by an ACTIVATE of the new row and then the access.
- R7: A request to a closed bank gets an ACTIVATE with the row on `sd_addr` and the bank on `sd_bank`.
- R8: `rd_data_valid` pulses once per READ, exactly `cfg_cas_lat`+1 cycles after the READ appears on `sd_cmd`. It never pulses for a WRITE.
- R9: With no open banks, AUTO-REFRESH repeats every `cfg_ref_interval` cycles (interval of 4 or more).
- R10: A due refresh takes priority over waiting requests and causes a PRECHARGE with `sd_addr[10]`=1, then AUTO-REFRESH. Afterwards every bank is closed, so the held request is served by a fresh ACTIVATE, and no accepted request is lost.
- R11: NOP (code 0) is driven in every cycle where no command is legal or wanted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Controller enable; low holds the sequencer idle |
| cfg_cas_lat | input | 2 | READ-to-data delay, value+1 cycles |
| cfg_pre_to_act | input | 2 | PRECHARGE/REFRESH-to-ACTIVATE/REFRESH gap, value+1 |
| cfg_rw_to_pre | input | 2 | READ/WRITE-to-PRECHARGE gap, value+1 |
| cfg_act_to_rw | input | 2 | ACTIVATE-to-READ/WRITE leadoff, value+1 |
| cfg_ref_interval | input | 16 | Refresh period in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Internal bank |
| req_row | input | 12 | Row address |
| req_col | input | 10 | Column address |
| sd_cmd | output | 3 | Command: 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE, 5 REFRESH |
| sd_addr | output | 12 | Row, column, or bit 10 = all-banks for PRE |
| sd_bank | output | 2 | Bank select |
| rd_data_valid | output | 1 | Read data valid strobe |

## Verification
The hardest situation to reach from the ports is a refresh falling due while a row is open and a request is already waiting. Only then do preemption, precharge-all and re-activation all happen together. The bench streams back-to-back row-hit reads across the moment the interval expires, so the demand lands mid-stream with the READ gap still running. Separately, all 256 combinations of the four delay fields are swept through a closed-bank, hit, then miss sequence. Each exact gap is compared with its field value plus one.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } seq_cmd_e;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_RUN      = 2'd1,
        ST_REF_WAIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/seq_gap_timer.sv
// Down counter: loaded with an encoded gap when a command is decided,
// reports zero once the next dependent command may be decided.
module seq_gap_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         reload,
    input  logic [W-1:0] interval,
    output logic         pending
);
    logic [W-1:0] cnt_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (!run || reload) begin
            cnt_q  <= interval - 1'b1;
            pend_q <= 1'b0;
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (cnt_q == W'(1)) pend_q <= 1'b1;
        end
    end

    assign pending = pend_q;

    // R9: once raised, demand stays until a refresh is issued or disabled
    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && run && !reload) |=> pend_q);
endmodule

// File: rtl/seq_row_tracker.sv
module seq_row_tracker #(
    parameter int BANKS = 4,
    parameter int ROW_W = 12,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         act,
    input  logic [BANK_W-1:0]            act_bank,
    input  logic [ROW_W-1:0]             act_row,
    input  logic                         pre_one,
    input  logic                         pre_all,
    input  logic [BANK_W-1:0]            pre_bank,
    output logic [BANKS-1:0]             open,
    output logic [BANKS-1:0][ROW_W-1:0]  row,
    output logic                         any_open
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open[b] <= 1'b0;
                row[b]  <= '0;
            end else if (pre_all || (pre_one && pre_bank == BANK_W'(b))) begin
                open[b] <= 1'b0;
            end else if (act && act_bank == BANK_W'(b)) begin
                open[b] <= 1'b1;
                row[b]  <= act_row;
            end
        end
    end

    assign any_open = |open;

    // R7: an ACTIVATE is only decided for a bank that is closed
    p_act_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> !open[act_bank]);
    // R6: a single-bank PRECHARGE only targets an open bank
    p_pre_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_one |-> open[pre_bank]);
endmodule

// File: rtl/seq_rd_pipe.sv
module seq_rd_pipe #(
    parameter int FLD_W = 2,
    localparam int DEPTH = 2 ** FLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_issued,
    input  logic [FLD_W-1:0] cas,
    output logic             rd_valid
);
    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[DEPTH-2:0], rd_issued};
    end

    assign rd_valid = pipe_q[cas];
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int FLD_W  = 2,
    parameter int REFI_W = 16,
    localparam int BANK_W = $clog2(BANKS),
    localparam int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [FLD_W-1:0]  cfg_cas_lat,
    input  logic [FLD_W-1:0]  cfg_pre_to_act,
    input  logic [FLD_W-1:0]  cfg_rw_to_pre,
    input  logic [FLD_W-1:0]  cfg_act_to_rw,
    input  logic [REFI_W-1:0] cfg_ref_interval,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [2:0]        sd_cmd,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_bank,
    output logic              rd_data_valid
);
    seq_state_e state_q, state_d;
    seq_cmd_e   cmd_q, cmd_d;
    logic [ROW_W-1:0]  addr_q, addr_d;
    logic [BANK_W-1:0] bank_q, bank_d;

    logic ldf_zero, ctp_zero, pta_zero, ref_pend;
    logic [BANKS-1:0]            trk_open;
    logic [BANKS-1:0][ROW_W-1:0] trk_row;
    logic any_open, row_hit;
    logic is_act, is_rw, is_pre, is_ref, pre_all, pre_one;

    assign row_hit = trk_open[req_bank] && (trk_row[req_bank] == req_row);

    // ---------------- decision logic ----------------
    always_comb begin
        state_d   = state_q;
        cmd_d     = CMD_NOP;
        addr_d    = '0;
        bank_d    = '0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_enable) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!cfg_enable) begin
                    state_d = ST_OFF;
                end else if (ref_pend) begin
                    if (any_open) begin
                        if (ctp_zero) begin
                            cmd_d          = CMD_PRE;
                            addr_d[AP_BIT] = 1'b1;
                            state_d        = ST_REF_WAIT;
                        end
                    end else if (pta_zero) begin
                        cmd_d = CMD_REF;
                    end
                end else if (req_valid) begin
                    bank_d = req_bank;
                    if (row_hit) begin
                        if (ldf_zero) begin
                            cmd_d              = req_write ? CMD_WR : CMD_RD;
                            addr_d[COL_W-1:0]  = req_col;
                            req_ready          = 1'b1;
                        end
                    end else if (trk_open[req_bank]) begin
                        if (ctp_zero) cmd_d = CMD_PRE;
                    end else if (pta_zero) begin
                        cmd_d  = CMD_ACT;
                        addr_d = req_row;
                    end
                end
            end
            ST_REF_WAIT: begin
                if (!cfg_enable) begin
                    state_d = ST_OFF;
                end else if (pta_zero) begin
                    cmd_d   = CMD_REF;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // ---------------- state and output registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
            bank_q  <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            bank_q  <= bank_d;
        end
    end

    assign sd_cmd  = cmd_q;
    assign sd_addr = addr_q;
    assign sd_bank = bank_q;

    assign is_act  = (cmd_d == CMD_ACT);
    assign is_rw   = (cmd_d == CMD_RD) || (cmd_d == CMD_WR);
    assign is_pre  = (cmd_d == CMD_PRE);
    assign is_ref  = (cmd_d == CMD_REF);
    assign pre_all = is_pre && addr_d[AP_BIT];
    assign pre_one = is_pre && !addr_d[AP_BIT];

    // ---------------- sub-blocks ----------------
    seq_gap_timer #(.W(FLD_W)) u_ldf (
        .clk(clk), .rst_n(rst_n), .load(is_act),
        .value(cfg_act_to_rw), .zero(ldf_zero));

    seq_gap_timer #(.W(FLD_W)) u_ctp (
        .clk(clk), .rst_n(rst_n), .load(is_rw),
        .value(cfg_rw_to_pre), .zero(ctp_zero));

    seq_gap_timer #(.W(FLD_W)) u_pta (
        .clk(clk), .rst_n(rst_n), .load(is_pre || is_ref),
        .value(cfg_pre_to_act), .zero(pta_zero));

    seq_refresh_timer #(.W(REFI_W)) u_refi (
        .clk(clk), .rst_n(rst_n), .run(cfg_enable), .reload(is_ref),
        .interval(cfg_ref_interval), .pending(ref_pend));

    seq_row_tracker #(.BANKS(BANKS), .ROW_W(ROW_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .act(is_act), .act_bank(bank_d), .act_row(addr_d),
        .pre_one(pre_one), .pre_all(pre_all), .pre_bank(bank_d),
        .open(trk_open), .row(trk_row), .any_open(any_open));

    seq_rd_pipe #(.FLD_W(FLD_W)) u_rdv (
        .clk(clk), .rst_n(rst_n), .rd_issued(cmd_q == CMD_RD),
        .cas(cfg_cas_lat), .rd_valid(rd_data_valid));

    // ---------------- assertions ----------------
    p_off_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (cmd_q == CMD_NOP));
    p_ready_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (state_q == ST_RUN && cfg_enable && req_valid));
    p_rw_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q inside {CMD_RD, CMD_WR}) |-> $past(ldf_zero));
    p_pre_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |-> $past(ctp_zero));
    p_act_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q inside {CMD_ACT, CMD_REF}) |-> $past(pta_zero));
    p_ref_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> !any_open);
endmodule

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [1:0]  cfg_cas_lat = '0, cfg_pre_to_act = '0, cfg_rw_to_pre = '0, cfg_act_to_rw = '0;
    logic [15:0] cfg_ref_interval = 16'd60000;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ready;
    logic [2:0]  sd_cmd;
    logic [11:0] sd_addr;
    logic [1:0]  sd_bank;
    logic        rd_data_valid;

    int checks = 0, errors = 0;
    int cyc = 0;
    int n_log = 0, n_rv = 0;
    int          log_cyc[4096];
    logic [2:0]  log_cmd[4096];
    logic [11:0] log_addr[4096];
    logic [1:0]  log_bank[4096];
    int          rv_cyc[4096];

    always #2 clk = ~clk;

    sdram_cmd_seq i_sdram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_cas_lat(cfg_cas_lat), .cfg_pre_to_act(cfg_pre_to_act),
        .cfg_rw_to_pre(cfg_rw_to_pre), .cfg_act_to_rw(cfg_act_to_rw),
        .cfg_ref_interval(cfg_ref_interval),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_bank(sd_bank),
        .rd_data_valid(rd_data_valid));

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && sd_cmd != 3'd0 && n_log < 4096) begin
            log_cyc[n_log] = cyc; log_cmd[n_log] = sd_cmd;
            log_addr[n_log] = sd_addr; log_bank[n_log] = sd_bank;
            n_log = n_log + 1;
        end
        if (rst_n && rd_data_valid && n_rv < 4096) begin
            rv_cyc[n_rv] = cyc;
            n_rv = n_rv + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input bit wr, input int bank, input int row, input int col);
        bit hs = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_bank = bank[1:0]; req_row = row[11:0]; req_col = col[9:0];
        while (!hs) begin
            #1; hs = req_ready;
            @(posedge clk);
            if (!hs) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk); req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input int cas, input int pta, input int ctp, input int ldf, input int refi);
        @(negedge clk);
        rst_n = 1'b0; cfg_enable = 1'b0; req_valid = 1'b0;
        cfg_cas_lat = cas[1:0]; cfg_pre_to_act = pta[1:0];
        cfg_rw_to_pre = ctp[1:0]; cfg_act_to_rw = ldf[1:0];
        cfg_ref_interval = refi[15:0];
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cfg_enable = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int b, rb, k;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 reset cmd", sd_cmd, 0);
        chk("R1 reset rd_valid", rd_data_valid, 0);
        rst_n = 1'b1;
        // R1: disabled with a request held: no command, no ready
        b = n_log;
        req_valid = 1'b1; req_bank = 2'd0; req_row = 12'd1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            chk("R1 ready low while disabled", req_ready, 0);
        end
        chk("R1 no command while disabled", n_log - b, 0);
        req_valid = 1'b0;

        // Sweep of all delay fields: closed bank, row hit, row miss
        for (int cas = 0; cas < 4; cas++)
        for (int pta = 0; pta < 4; pta++)
        for (int ctp = 0; ctp < 4; ctp++)
        for (int ldf = 0; ldf < 4; ldf++) begin
            restart(cas, pta, ctp, ldf, 60000);
            b = n_log; rb = n_rv;
            send(1'b0, 1, 5, 7);
            send(1'b1, 1, 5, 9);
            send(1'b0, 1, 6, 3);
            idle(12);
            chk("R11 command count", n_log - b, 6);
            if (n_log - b == 6) begin
                chk("R7 act code", log_cmd[b], 1);
                chk("R7 act row", log_addr[b], 5);
                chk("R7 act bank", log_bank[b], 1);
                chk("R2 act to read gap", log_cyc[b+1] - log_cyc[b], ldf + 1);
                chk("R5 read code", log_cmd[b+1], 2);
                chk("R5 read column", log_addr[b+1], 7);
                chk("R5 read bank", log_bank[b+1], 1);
                chk("R5 hit write code", log_cmd[b+2], 3);
                chk("R5 hit write column", log_addr[b+2], 9);
                chk("R6 pre code", log_cmd[b+3], 4);
                chk("R6 pre single bank bit10", log_addr[b+3][10], 0);
                chk("R6 pre bank", log_bank[b+3], 1);
                chk("R3 write to pre gap", log_cyc[b+3] - log_cyc[b+2], ctp + 1);
                chk("R6 act code", log_cmd[b+4], 1);
                chk("R6 act new row", log_addr[b+4], 6);
                chk("R4 pre to act gap", log_cyc[b+4] - log_cyc[b+3], pta + 1);
                chk("R6 read code", log_cmd[b+5], 2);
                chk("R2 act to read gap after miss", log_cyc[b+5] - log_cyc[b+4], ldf + 1);
                chk("R8 strobe count", n_rv - rb, 2);
                if (n_rv - rb == 2) begin
                    chk("R8 first strobe", rv_cyc[rb] - log_cyc[b+1], cas + 1);
                    chk("R8 second strobe", rv_cyc[rb+1] - log_cyc[b+5], cas + 1);
                end
            end
        end

        // R9: idle refresh period
        restart(1, 1, 2, 1, 20);
        b = n_log;
        repeat (72) @(negedge clk);
        chk("R9 refresh count", n_log - b, 3);
        if (n_log - b == 3) begin
            for (int i = 0; i < 3; i++) chk("R9 refresh code", log_cmd[b+i], 5);
            chk("R9 period 1", log_cyc[b+1] - log_cyc[b], 20);
            chk("R9 period 2", log_cyc[b+2] - log_cyc[b+1], 20);
        end

        // R10: refresh falling due inside a stream of row-hit reads
        restart(2, 2, 1, 1, 30);
        b = n_log;
        for (int i = 0; i < 40; i++) send(1'b0, 2, 9, i);
        idle(15);
        k = -1;
        for (int i = b; i < n_log; i++) if (k < 0 && log_cmd[i] == 3'd5) k = i;
        chk("R10 refresh seen", (k >= b + 3 && k + 2 < n_log) ? 1 : 0, 1);
        if (k >= b + 3 && k + 2 < n_log) begin
            chk("R10 precharge before refresh", log_cmd[k-1], 4);
            chk("R10 precharge all bit10", log_addr[k-1][10], 1);
            chk("R3 read to precharge-all gap", log_cyc[k-1] - log_cyc[k-2], 2);
            chk("R4 precharge-all to refresh gap", log_cyc[k] - log_cyc[k-1], 3);
            chk("R10 reactivate after refresh", log_cmd[k+1], 1);
            chk("R10 reactivate row", log_addr[k+1], 9);
            chk("R10 reactivate bank", log_bank[k+1], 2);
            chk("R4 refresh to act gap", log_cyc[k+1] - log_cyc[k], 3);
            chk("R2 act to read after refresh", log_cyc[k+2] - log_cyc[k+1], 2);
        end
        begin
            int nrd = 0;
            for (int i = b; i < n_log; i++) if (log_cmd[i] == 3'd2) nrd++;
            chk("R10 all reads issued", nrd, 40);
        end

        // R1: disable mid-operation with a request held
        @(negedge clk);
        cfg_enable = 1'b0;
        req_valid = 1'b1; req_bank = 2'd3; req_row = 12'd4;
        @(negedge clk);
        b = n_log;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            chk("R1 ready low after disable", req_ready, 0);
        end
        chk("R1 no command after disable", n_log - b, 0);
        req_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule